// File: doc/BRIEF.md
# Tuner Control Write Port over I2C

This block is a receive-only I2C target that a tuning phase-locked loop uses to take its settings from a host processor. It watches SCL and SDA, which have already been brought into the block's clock domain, and finds start and stop conditions. It takes in bytes most significant bit first on SCL rising edges and pulls SDA low through an open-drain output during the ninth clock of each byte it accepts. The address byte is compared against a fixed five-bit prefix followed by two bits from a chip-select input and a write direction bit. With the two select bits, up to four of these blocks can share one bus.

After the address, data bytes arrive in pairs. The most significant bit of the first byte of a pair picks what the pair carries. A 0 means the upper and then the lower part of a 15-bit divider ratio. A 1 means two control words: the pump current select, the test routing, the pump disable and the filter-output disable, and then the band and port outputs. A telegram may carry one pair, two pairs in either order, or a pair and then a single first byte of the other kind. Every field is written at the moment the block starts acknowledging the byte, so the outputs change only while SDA is being held low.

Top module: `tnr_i2c_tuner`

## Requirements
- R1: A start is SDA going 1->0 while SCL is 1, and a stop is SDA going 0->1 while SCL is 1. Data bits are taken MSB first on SCL rising edges while no start or stop is seen.
- R2: An address byte equal to binary 1 1 0 0 0 cs[1] cs[0] 0 (MSB first, last bit 0 = write) is acknowledged. sda_pull_o goes to 1 after the SCL falling edge that ends the eighth bit, stays at 1 through the ninth SCL high phase, and goes to 0 after the ninth falling edge.
- R3: An address byte of any other value, including the matching address with the last bit 1, gets no acknowledge. All bytes up to the next start are then neither acknowledged nor stored.
- R4: If bit 7 of the first data byte is 0, its bits 6..0 load div_ratio_o[14:8], and the next byte loads div_ratio_o[7:0].
- R5: If bit 7 of the first data byte is 1, its bit 6 loads pump_hi_o, bit 5 loads test_route_o, bit 4 loads pump_off_o and bit 0 loads filt_dis_o. The next byte loads port_o[3:0] from bits 7..4 and band_o[2:0] from bits 2..0.
- R6: Bit 7 of the third data byte picks the kind of the third and fourth bytes in the same way, so either kind may come first.
- R7: A first byte that is not followed by its second byte updates only its own fields. The fields of the second byte keep their values.
- R8: A fifth or later data byte in a telegram is acknowledged but changes no output.
- R9: A start received in the middle of a telegram (repeated start) returns the block to address matching, whether the telegram before it was accepted or ignored.
- R10: Reset clears div_ratio_o, all control and port outputs, and sda_pull_o to 0.
- R11: Every data byte after a matching address is acknowledged. Outputs change only in clock cycles where sda_pull_o is 1, and a stop forces sda_pull_o to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data as seen on the bus |
| chip_sel_i | input | 2 | Selects address bits 2..1 |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| div_ratio_o | output | 15 | Programmable divider ratio |
| pump_hi_o | output | 1 | High pump current select |
| test_route_o | output | 1 | Route test signals to ports |
| pump_off_o | output | 1 | Charge pump forced off |
| filt_dis_o | output | 1 | Filter output disable |
| band_o | output | 3 | Band select outputs |
| port_o | output | 4 | General port outputs |

## Verification
Directed telegrams cover each pair order, a pair followed by one lone byte of either kind, and a five-byte telegram. Together they show that the kind is picked from the first and third bytes only and that a fifth byte is dropped. Addresses wrong in one prefix bit, in a select bit or in the direction bit show that the comparison covers the whole byte, and a repeated start after a rejected address shows that matching begins again. Random telegrams with random select values, lengths, contents and mostly matching addresses are checked against a bench model of the fields after every stop, and each acknowledge bit is checked as it happens.

// File: rtl/tnr_pkg.sv
package tnr_pkg;

    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 15;
    localparam int SEL_W    = 2;
    localparam int PORT_W   = 4;
    localparam int BAND_W   = 3;

    // fixed upper part of the target address
    localparam logic [4:0] ADDR_PREFIX = 5'b11000;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA,
        RX_SKIP
    } rx_state_e;

    typedef enum logic {
        PAIR_DIV = 1'b0,
        PAIR_CTL = 1'b1
    } pair_kind_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic pump_hi;
        logic test_route;
        logic pump_off;
        logic filt_dis;
    } ctl_a_t;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [BAND_W-1:0] band;
    } ctl_b_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [SEL_W-1:0]  sel);
        return b == {ADDR_PREFIX, sel, 1'b0};
    endfunction

    function automatic ctl_a_t decode_ctl_a(input logic [BYTE_W-1:0] b);
        ctl_a_t c;
        c.pump_hi    = b[6];
        c.test_route = b[5];
        c.pump_off   = b[4];
        c.filt_dis   = b[0];
        return c;
    endfunction

    function automatic ctl_b_t decode_ctl_b(input logic [BYTE_W-1:0] b);
        ctl_b_t c;
        c.port = b[7:4];
        c.band = b[2:0];
        return c;
    endfunction

endpackage

// File: rtl/tnr_bus_events.sv
module tnr_bus_events
    import tnr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA may only move while SCL is high for a start or a stop
    always_comb begin
        evt_o.start = scl_i && scl_q && sda_q && !sda_i;
        evt_o.stop  = scl_i && scl_q && !sda_q && sda_i;
        evt_o.rise  = scl_i && !scl_q;
        evt_o.fall  = !scl_i && scl_q;
    end

endmodule

// File: rtl/tnr_byte_rx.sv
module tnr_byte_rx
    import tnr_pkg::*;
#(
    parameter int BYTES_MAX = 4,
    localparam int CNT_W = $clog2(BYTES_MAX + 1),
    localparam int IDX_W = (BYTES_MAX > 1) ? $clog2(BYTES_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              ack_o,
    output logic              wr_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic [IDX_W-1:0]  wr_idx_o
);

    localparam logic [3:0] BIT_LAST = 4'd8;
    localparam logic [3:0] BIT_ACK  = 4'd9;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTES_MAX);

    rx_state_e          state_q;
    logic [3:0]         bit_cnt_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic [CNT_W-1:0]   data_cnt_q;
    logic               ack_q;

    logic byte_done;
    logic ack_done;
    logic active;

    assign active    = (state_q == RX_ADDR) || (state_q == RX_DATA);
    assign byte_done = active && evt_i.fall && (bit_cnt_q == BIT_LAST);
    assign ack_done  = active && evt_i.fall && (bit_cnt_q == BIT_ACK);

    // a data byte is stored on the falling edge that opens its acknowledge
    always_comb begin
        wr_o      = byte_done && (state_q == RX_DATA) && (data_cnt_q < CNT_FULL);
        wr_byte_o = shreg_q;
        wr_idx_o  = data_cnt_q[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_IDLE;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            data_cnt_q <= '0;
            ack_q      <= 1'b0;
        end else if (evt_i.start) begin
            state_q    <= RX_ADDR;
            bit_cnt_q  <= '0;
            data_cnt_q <= '0;
            ack_q      <= 1'b0;
        end else if (evt_i.stop) begin
            state_q   <= RX_IDLE;
            bit_cnt_q <= '0;
            ack_q     <= 1'b0;
        end else if (active) begin
            if (evt_i.rise) begin
                if (bit_cnt_q < BIT_LAST) begin
                    shreg_q   <= {shreg_q[BYTE_W-2:0], sda_i};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else if (bit_cnt_q == BIT_LAST) begin
                    bit_cnt_q <= BIT_ACK;
                end
            end else if (byte_done) begin
                if (state_q == RX_ADDR) begin
                    if (addr_hit(shreg_q, sel_i)) begin
                        ack_q <= 1'b1;
                    end else begin
                        state_q <= RX_SKIP;
                    end
                end else begin
                    ack_q <= 1'b1;
                    if (data_cnt_q < CNT_FULL) begin
                        data_cnt_q <= data_cnt_q + 1'b1;
                    end
                end
            end else if (ack_done) begin
                ack_q     <= 1'b0;
                bit_cnt_q <= '0;
                if (state_q == RX_ADDR) begin
                    state_q <= RX_DATA;
                end
            end
        end
    end

    assign ack_o = ack_q;

endmodule

// File: rtl/tnr_reg_bank.sv
module tnr_reg_bank
    import tnr_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    output logic [DIV_W-1:0]  div_o,
    output ctl_a_t            ctl_a_o,
    output ctl_b_t            ctl_b_o
);

    localparam int DIV_HI_W = DIV_W - BYTE_W;

    pair_kind_e          kind_q;
    pair_kind_e          kind_now;
    logic                first_of_pair;
    logic [DIV_W-1:0]    div_q;
    ctl_a_t              ctl_a_q;
    ctl_b_t              ctl_b_q;
    logic                unused_gap_bits;

    // even byte positions open a pair and choose its kind
    assign first_of_pair = !wr_idx_i[0];
    assign kind_now      = first_of_pair ? pair_kind_e'(wr_byte_i[BYTE_W-1]) : kind_q;
    assign unused_gap_bits = ^{wr_byte_i[3:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= PAIR_DIV;
            div_q   <= '0;
            ctl_a_q <= '0;
            ctl_b_q <= '0;
        end else if (wr_i) begin
            if (first_of_pair) begin
                kind_q <= kind_now;
            end
            unique case ({kind_now, first_of_pair})
                {PAIR_DIV, 1'b1}: div_q[DIV_W-1:BYTE_W] <= wr_byte_i[DIV_HI_W-1:0];
                {PAIR_DIV, 1'b0}: div_q[BYTE_W-1:0]     <= wr_byte_i;
                {PAIR_CTL, 1'b1}: ctl_a_q               <= decode_ctl_a(wr_byte_i);
                {PAIR_CTL, 1'b0}: ctl_b_q               <= decode_ctl_b(wr_byte_i);
                default: ;
            endcase
        end
    end

    assign div_o   = div_q;
    assign ctl_a_o = ctl_a_q;
    assign ctl_b_o = ctl_b_q;

endmodule

// File: rtl/tnr_i2c_tuner.sv
module tnr_i2c_tuner
    import tnr_pkg::*;
#(
    parameter int BYTES_MAX = 4,
    localparam int IDX_W = (BYTES_MAX > 1) ? $clog2(BYTES_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [SEL_W-1:0]  chip_sel_i,
    output logic              sda_pull_o,
    output logic [DIV_W-1:0]  div_ratio_o,
    output logic              pump_hi_o,
    output logic              test_route_o,
    output logic              pump_off_o,
    output logic              filt_dis_o,
    output logic [BAND_W-1:0] band_o,
    output logic [PORT_W-1:0] port_o
);

    bus_evt_t           evt;
    logic               wr;
    logic [BYTE_W-1:0]  wr_byte;
    logic [IDX_W-1:0]   wr_idx;
    ctl_a_t             ctl_a;
    ctl_b_t             ctl_b;

    tnr_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    tnr_byte_rx #(
        .BYTES_MAX (BYTES_MAX)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .sda_i     (sda_i),
        .sel_i     (chip_sel_i),
        .ack_o     (sda_pull_o),
        .wr_o      (wr),
        .wr_byte_o (wr_byte),
        .wr_idx_o  (wr_idx)
    );

    tnr_reg_bank #(
        .IDX_W (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .wr_byte_i (wr_byte),
        .wr_idx_i  (wr_idx),
        .div_o     (div_ratio_o),
        .ctl_a_o   (ctl_a),
        .ctl_b_o   (ctl_b)
    );

    assign pump_hi_o    = ctl_a.pump_hi;
    assign test_route_o = ctl_a.test_route;
    assign pump_off_o   = ctl_a.pump_off;
    assign filt_dis_o   = ctl_a.filt_dis;
    assign band_o       = ctl_b.band;
    assign port_o       = ctl_b.port;

endmodule

// File: rtl/tnr_i2c_tuner_chk.sv
module tnr_i2c_tuner_chk
    import tnr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_pull_o,
    input logic [DIV_W-1:0]  div_ratio_o,
    input logic              pump_hi_o,
    input logic              test_route_o,
    input logic              pump_off_o,
    input logic              filt_dis_o,
    input logic [BAND_W-1:0] band_o,
    input logic [PORT_W-1:0] port_o
);

    logic p_scl;
    logic p_sda;
    logic p_rst;
    logic stop_seen;
    logic [25:0] regs_now;

    assign regs_now  = {div_ratio_o, pump_hi_o, test_route_o, pump_off_o,
                        filt_dis_o, band_o, port_o};
    assign stop_seen = scl_i && p_scl && !p_sda && sda_i;

    always_ff @(posedge clk) begin
        if (p_rst) begin
            assert_reset_zero_R10: assert (regs_now == '0 && !sda_pull_o)
                else $error("outputs not cleared by reset");
        end
        p_rst <= rst;
        if (rst) begin
            p_scl <= 1'b1;
            p_sda <= 1'b1;
        end else begin
            p_scl <= scl_i;
            p_sda <= sda_i;
        end
    end

    assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !sda_pull_o);

    assert_ack_starts_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !$past(scl_i));

    assert_write_in_ack_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(regs_now) |-> sda_pull_o);

endmodule

bind tnr_i2c_tuner tnr_i2c_tuner_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl_i),
    .sda_i        (sda_i),
    .sda_pull_o   (sda_pull_o),
    .div_ratio_o  (div_ratio_o),
    .pump_hi_o    (pump_hi_o),
    .test_route_o (test_route_o),
    .pump_off_o   (pump_off_o),
    .filt_dis_o   (filt_dis_o),
    .band_o       (band_o),
    .port_o       (port_o)
);

// File: tb/tnr_i2c_tuner_bench.sv
module tnr_i2c_tuner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        drv_sda = 1'b1;
    logic        sda_bus;
    logic [1:0]  cs = 2'b00;

    logic        sda_pull;
    logic [14:0] div_ratio;
    logic        pump_hi, test_route, pump_off, filt_dis;
    logic [2:0]  band;
    logic [3:0]  port;

    int n_tests = 0;
    int n_fail  = 0;

    // expected state
    logic [14:0] e_div;
    logic        e_ph, e_tr, e_po, e_fd;
    logic [2:0]  e_band;
    logic [3:0]  e_port;
    logic        e_kind;
    logic [7:0]  tx_buf [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = drv_sda & ~sda_pull;

    tnr_i2c_tuner u_tnr_i2c_tuner (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl),
        .sda_i        (sda_bus),
        .chip_sel_i   (cs),
        .sda_pull_o   (sda_pull),
        .div_ratio_o  (div_ratio),
        .pump_hi_o    (pump_hi),
        .test_route_o (test_route),
        .pump_off_o   (pump_off),
        .filt_dis_o   (filt_dis),
        .band_o       (band),
        .port_o       (port)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        drv_sda = 1'b1; wq();
        scl = 1'b1;     wq();
        drv_sda = 1'b0; wq();
        scl = 1'b0;     wq();
    endtask

    task automatic bus_stop();
        drv_sda = 1'b0; wq();
        scl = 1'b1;     wq();
        drv_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            drv_sda = b[i]; wq();
            scl = 1'b1;     wq();
            scl = 1'b0;     wq();
        end
        drv_sda = 1'b1; wq();
        scl = 1'b1;     wq();
        acked = sda_pull;
        scl = 1'b0;     wq();
    endtask

    function automatic logic [7:0] addr_of(input logic [1:0] sel);
        return {5'b11000, sel, 1'b0};
    endfunction

    // bench model of one stored data byte
    task automatic model_byte(input int idx, input logic [7:0] b);
        if (idx >= 4) return;
        if (idx % 2 == 0) e_kind = b[7];
        if (!e_kind && idx % 2 == 0) e_div[14:8] = b[6:0];
        else if (!e_kind)            e_div[7:0]  = b;
        else if (idx % 2 == 0) begin
            e_ph = b[6]; e_tr = b[5]; e_po = b[4]; e_fd = b[0];
        end else begin
            e_port = b[7:4]; e_band = b[2:0];
        end
    endtask

    task automatic check_regs(input string req);
        check(req, {6'd0, div_ratio, pump_hi, test_route, pump_off, filt_dis, band, port},
                   {6'd0, e_div, e_ph, e_tr, e_po, e_fd, e_band, e_port});
    endtask

    // address plus n data bytes from tx_buf, then optional stop
    task automatic telegram(input logic [7:0] addr, input int n, input bit do_stop,
                            input string req);
        logic ack;
        logic hit;
        hit = (addr == addr_of(cs));
        bus_start();
        send_byte(addr, ack);
        check({req, " R2 R3 address ack"}, {31'd0, ack}, {31'd0, hit});
        for (int i = 0; i < n; i++) begin
            send_byte(tx_buf[i], ack);
            check({req, " R11 R3 data ack"}, {31'd0, ack}, {31'd0, hit});
            if (hit) model_byte(i, tx_buf[i]);
        end
        if (do_stop) begin
            bus_stop();
            check({req, " R11 released after stop"}, {31'd0, sda_pull}, 32'd0);
            check_regs(req);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ack;
        void'($urandom(32'd4242));
        e_div = '0; e_ph = 0; e_tr = 0; e_po = 0; e_fd = 0;
        e_band = '0; e_port = '0; e_kind = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_regs("R10 reset state");
        check("R10 no pull after reset", {31'd0, sda_pull}, 32'd0);

        // R4 R5 R6: divider pair then control pair
        cs = 2'b01;
        tx_buf[0] = 8'h2B; tx_buf[1] = 8'hC4; tx_buf[2] = 8'hD1; tx_buf[3] = 8'hA5;
        telegram(addr_of(cs), 4, 1, "R4 R5 R6 div-then-ctl");

        // R6: control pair then divider pair
        cs = 2'b10;
        tx_buf[0] = 8'hAE; tx_buf[1] = 8'h5A; tx_buf[2] = 8'h7F; tx_buf[3] = 8'h00;
        telegram(addr_of(cs), 4, 1, "R6 ctl-then-div");
        check("R4 div value", {17'd0, div_ratio}, 32'h7F00);

        // R7: divider pair plus lone control byte
        cs = 2'b11;
        tx_buf[0] = 8'h01; tx_buf[1] = 8'h23; tx_buf[2] = 8'hF1;
        telegram(addr_of(cs), 3, 1, "R7 lone ctl byte");
        check("R7 ports kept", {28'd0, port}, 32'h5);

        // R7: control pair plus lone divider byte
        tx_buf[0] = 8'h80; tx_buf[1] = 8'h0F; tx_buf[2] = 8'h15;
        telegram(addr_of(cs), 3, 1, "R7 lone div byte");
        check("R7 div low kept", {24'd0, div_ratio[7:0]}, 32'h23);

        // R8: fifth byte acknowledged and discarded
        cs = 2'b00;
        tx_buf[0] = 8'h12; tx_buf[1] = 8'h34; tx_buf[2] = 8'hC0; tx_buf[3] = 8'hF7;
        tx_buf[4] = 8'h7F;
        telegram(addr_of(cs), 5, 1, "R8 fifth byte");

        // R3: wrong prefix bit, wrong select, read direction
        tx_buf[0] = 8'h55; tx_buf[1] = 8'hFF; tx_buf[2] = 8'hEE; tx_buf[3] = 8'h77;
        telegram(8'hC8, 4, 1, "R3 bad prefix");
        telegram(addr_of(2'b10), 4, 1, "R3 bad select");
        telegram(addr_of(cs) | 8'h01, 4, 1, "R3 read bit");

        // R9: rejected address, repeated start, accepted address
        tx_buf[0] = 8'h66;
        telegram(8'h00, 1, 0, "R9 rejected part");
        tx_buf[0] = 8'h3C; tx_buf[1] = 8'h99;
        telegram(addr_of(cs), 2, 1, "R9 after repeated start");

        // R9: accepted part, repeated start to another address is ignored
        tx_buf[0] = 8'hB3;
        telegram(addr_of(cs), 1, 0, "R9 accepted part");
        tx_buf[0] = 8'h00; tx_buf[1] = 8'h00;
        telegram(addr_of(2'b01), 2, 1, "R9 ignored after repeated start");

        // R1: SCL pulses with no start give no ack and no change
        for (int i = 0; i < 9; i++) begin
            scl = 1'b1; wq(); scl = 1'b0; wq();
            check("R1 no ack without start", {31'd0, sda_pull}, 32'd0);
        end
        scl = 1'b1; wq();
        check_regs("R1 idle pulses");

        // random telegrams
        for (int t = 0; t < 45; t++) begin
            logic [7:0] a;
            int n;
            cs = 2'($urandom_range(0, 3));
            a  = addr_of(cs);
            if ($urandom_range(0, 4) == 0) a = a ^ (8'd1 << $urandom_range(0, 7));
            n = $urandom_range(1, 5);
            for (int i = 0; i < n; i++) tx_buf[i] = 8'($urandom);
            telegram(a, n, 1, "R4 R5 R6 R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule